// File: doc/BRIEF.md
# Aligned Line Burst Splitter

This block turns one line fetch into a series of read burst commands for a memory interconnect that moves 128 bits (16 bytes) per beat. A line is given as a 48-bit start byte address and a byte length. The block rounds the start down to a beat boundary and the end up to one. It then covers that span with bursts of 1, 2, 4 or 8 beats. Each burst starts on a multiple of its own byte size, and no burst runs past the end of the line.

At every step the block picks the longest burst that is aligned at the current beat and still fits in the beats that remain. A misaligned head or a short tail is therefore split into smaller power-of-two bursts. Commands leave one at a time on a valid/ready handshake. The block holds one line at a time, so a new line is taken only after the final burst of the current line has been accepted. A zero-length line is taken at once and produces no command.

Top module: `line_burst_splitter`

## Requirements
- R1: After reset, `line_ready_o` is 1 and `burst_valid_o` is 0.
- R2: The first burst of a line starts at the line start address with its low 4 bits cleared. Every later burst starts at the previous burst address plus the previous burst's byte size (16 × beats).
- R3: The bursts of a line with byte length L > 0 starting at byte address A together cover exactly ceil(((A mod 16) + L) / 16) beats. After the last of them no further burst is issued for that line.
- R4: `burst_len_o` is coded as 0 = 1 beat, 1 = 2 beats, 2 = 4 beats, 3 = 8 beats.
- R5: Every burst address is a multiple of 16 × (its beat count).
- R6: Each burst is the longest of the four lengths that is aligned at the current beat and does not exceed the remaining beat count.
- R7: `burst_last_o` is 1 on the final burst of a line and 0 on all others.
- R8: A line request with length 0 is accepted in one cycle and yields no burst. `line_ready_o` stays 1 in the next cycle.
- R9: While `burst_valid_o` is 1 and `burst_ready_i` is 0, the command (address, length, last flag) holds stable and valid stays 1.
- R10: Once a non-empty line is accepted, `line_ready_o` is 0 until the cycle after the last burst is accepted. In that cycle `line_ready_o` is 1 and `burst_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_valid_i | input | 1 | Line request present |
| line_ready_o | output | 1 | Block can accept a line |
| line_addr_i | input | 48 | Start byte address of the line |
| line_len_i | input | 16 | Line length in bytes |
| burst_valid_o | output | 1 | Burst command present |
| burst_ready_i | input | 1 | Interconnect accepts the command |
| burst_addr_o | output | 48 | Beat-aligned burst byte address |
| burst_len_o | output | 2 | Burst length code |
| burst_last_o | output | 1 | Final burst of the line |

## Verification
The assertions check several properties on every cycle. Each burst must be aligned to its own size, and consecutive bursts of a line must be address-contiguous. A stalled command must stay unchanged. The checks also cover the handoff: line_ready stays low while bursts are pending, returns after the final one, and comes back at once for an empty line. Only the bench scenarios can show that the block picks the longest legal burst, covers the right number of beats and marks the last flag on the right burst. These depend on the requested line and are compared against an arithmetic model, which is swept over many start offsets and lengths with and without back-pressure.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  localparam int unsigned LBS_ADDR_W     = 48;
  localparam int unsigned LBS_LEN_W      = 16;
  localparam int unsigned LBS_BEAT_BYTES = 16;
  localparam int unsigned LBS_NUM_SIZES  = 4;
endpackage

// File: rtl/lbs_span_calc.sv
module lbs_span_calc #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned OFS_W  = 4,
  parameter int unsigned BEAT_W = ADDR_W - OFS_W,
  parameter int unsigned CNT_W  = LEN_W + 1 - OFS_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [BEAT_W-1:0] start_beat_o,
  output logic [CNT_W-1:0]  beat_cnt_o
);
  localparam int unsigned SUM_W = LEN_W + 1;

  logic [SUM_W-1:0] span_bytes;

  // byte offset inside first beat + length, rounded up to whole beats
  always_comb begin
    span_bytes = {1'b0, len_i}
               + SUM_W'(addr_i[OFS_W-1:0])
               + SUM_W'((1 << OFS_W) - 1);
    start_beat_o = addr_i[ADDR_W-1:OFS_W];
    beat_cnt_o   = (len_i == '0) ? '0 : span_bytes[SUM_W-1:OFS_W];
  end
endmodule

// File: rtl/lbs_size_pick.sv
module lbs_size_pick #(
  parameter int unsigned BEAT_W    = 44,
  parameter int unsigned CNT_W     = 13,
  parameter int unsigned NUM_SIZES = 4,
  parameter int unsigned CODE_W    = $clog2(NUM_SIZES)
) (
  input  logic [BEAT_W-1:0] cur_beat_i,
  input  logic [CNT_W-1:0]  rem_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CNT_W-1:0]  step_o,
  output logic              last_o
);
  logic [NUM_SIZES-1:0] fit;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_fit
    if (g == 0) begin : g_unit
      assign fit[g] = (rem_i != '0);
    end else begin : g_pow
      assign fit[g] = (cur_beat_i[g-1:0] == '0) && (rem_i >= (CNT_W'(1) << g));
    end
  end

  // ascending scan: highest fitting size wins
  always_comb begin
    code_o = '0;
    for (int i = 0; i < NUM_SIZES; i++) begin
      if (fit[i]) code_o = CODE_W'(i);
    end
    step_o = CNT_W'(1) << code_o;
    last_o = (rem_i == step_o);
  end
endmodule

// File: rtl/lbs_walker.sv
module lbs_walker #(
  parameter int unsigned BEAT_W = 44,
  parameter int unsigned CNT_W  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_fire_i,
  input  logic [BEAT_W-1:0] start_beat_i,
  input  logic [CNT_W-1:0]  beat_cnt_i,
  input  logic              burst_fire_i,
  input  logic [CNT_W-1:0]  step_i,
  input  logic              last_i,
  output logic              busy_o,
  output logic [BEAT_W-1:0] cur_beat_o,
  output logic [CNT_W-1:0]  rem_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      cur_beat_o <= '0;
      rem_o      <= '0;
    end else if (line_fire_i) begin
      busy_o     <= (beat_cnt_i != '0);
      cur_beat_o <= start_beat_i;
      rem_o      <= beat_cnt_i;
    end else if (burst_fire_i) begin
      cur_beat_o <= cur_beat_o + BEAT_W'(step_i);
      rem_o      <= rem_o - step_i;
      if (last_i) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/line_burst_splitter.sv
module line_burst_splitter
  import lbs_pkg::*;
#(
  parameter int unsigned ADDR_W     = LBS_ADDR_W,
  parameter int unsigned LEN_W      = LBS_LEN_W,
  parameter int unsigned BEAT_BYTES = LBS_BEAT_BYTES,
  parameter int unsigned NUM_SIZES  = LBS_NUM_SIZES,
  localparam int unsigned OFS_W     = $clog2(BEAT_BYTES),
  localparam int unsigned BEAT_W    = ADDR_W - OFS_W,
  localparam int unsigned CNT_W     = LEN_W + 1 - OFS_W,
  localparam int unsigned CODE_W    = $clog2(NUM_SIZES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_valid_i,
  output logic              line_ready_o,
  input  logic [ADDR_W-1:0] line_addr_i,
  input  logic [LEN_W-1:0]  line_len_i,
  output logic              burst_valid_o,
  input  logic              burst_ready_i,
  output logic [ADDR_W-1:0] burst_addr_o,
  output logic [CODE_W-1:0] burst_len_o,
  output logic              burst_last_o
);
  logic [BEAT_W-1:0] start_beat, cur_beat;
  logic [CNT_W-1:0]  beat_cnt, rem, step;
  logic              busy, last, line_fire, burst_fire;

  assign line_ready_o  = !busy;
  assign line_fire     = line_valid_i && line_ready_o;
  assign burst_valid_o = busy;
  assign burst_fire    = burst_valid_o && burst_ready_i;

  lbs_span_calc #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFS_W(OFS_W), .BEAT_W(BEAT_W), .CNT_W(CNT_W)
  ) span_i (
    .addr_i      (line_addr_i),
    .len_i       (line_len_i),
    .start_beat_o(start_beat),
    .beat_cnt_o  (beat_cnt)
  );

  lbs_size_pick #(
    .BEAT_W(BEAT_W), .CNT_W(CNT_W), .NUM_SIZES(NUM_SIZES), .CODE_W(CODE_W)
  ) pick_i (
    .cur_beat_i(cur_beat),
    .rem_i     (rem),
    .code_o    (burst_len_o),
    .step_o    (step),
    .last_o    (last)
  );

  lbs_walker #(
    .BEAT_W(BEAT_W), .CNT_W(CNT_W)
  ) walk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_fire_i (line_fire),
    .start_beat_i(start_beat),
    .beat_cnt_i  (beat_cnt),
    .burst_fire_i(burst_fire),
    .step_i      (step),
    .last_i      (last),
    .busy_o      (busy),
    .cur_beat_o  (cur_beat),
    .rem_o       (rem)
  );

  assign burst_addr_o = {cur_beat, OFS_W'(0)};
  assign burst_last_o = busy && last;
endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
  parameter int unsigned ADDR_W     = 48,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned BEAT_BYTES = 16,
  parameter int unsigned CODE_W     = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              line_valid_i,
  input logic              line_ready_o,
  input logic [ADDR_W-1:0] line_addr_i,
  input logic [LEN_W-1:0]  line_len_i,
  input logic              burst_valid_o,
  input logic              burst_ready_i,
  input logic [ADDR_W-1:0] burst_addr_o,
  input logic [CODE_W-1:0] burst_len_o,
  input logic              burst_last_o
);
  logic              have_prev;
  logic [ADDR_W-1:0] next_addr;
  logic [ADDR_W-1:0] burst_bytes;

  assign burst_bytes = ADDR_W'(BEAT_BYTES) << burst_len_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev <= 1'b0;
      next_addr <= '0;
    end else if (burst_valid_o && burst_ready_i) begin
      have_prev <= !burst_last_o;
      next_addr <= burst_addr_o + burst_bytes;
    end
  end

  assert_contiguous_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_valid_o && have_prev |-> burst_addr_o == next_addr);

  assert_self_aligned_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_valid_o |-> (burst_addr_o & (burst_bytes - 1'b1)) == '0);

  assert_empty_line_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_i && line_ready_o && line_len_i == '0 |=> line_ready_o && !burst_valid_o);

  assert_hold_on_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_valid_o && !burst_ready_i |=> burst_valid_o && $stable(burst_addr_o)
      && $stable(burst_len_o) && $stable(burst_last_o));

  assert_line_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_i && line_ready_o && line_len_i != '0 |=> burst_valid_o && !line_ready_o);

  assert_pending_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_valid_o && !(burst_ready_i && burst_last_o) |=> !line_ready_o);

  assert_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_valid_o && burst_ready_i && burst_last_o |=> line_ready_o && !burst_valid_o);
endmodule

bind line_burst_splitter lbs_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES), .CODE_W(CODE_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .line_valid_i (line_valid_i),
  .line_ready_o (line_ready_o),
  .line_addr_i  (line_addr_i),
  .line_len_i   (line_len_i),
  .burst_valid_o(burst_valid_o),
  .burst_ready_i(burst_ready_i),
  .burst_addr_o (burst_addr_o),
  .burst_len_o  (burst_len_o),
  .burst_last_o (burst_last_o)
);

// File: tb/line_burst_splitter_tb_top.sv
module line_burst_splitter_tb_top;
  localparam int ADDR_W = 48;
  localparam int LEN_W  = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              line_valid_i;
  logic              line_ready_o;
  logic [ADDR_W-1:0] line_addr_i;
  logic [LEN_W-1:0]  line_len_i;
  logic              burst_valid_o;
  logic              burst_ready_i;
  logic [ADDR_W-1:0] burst_addr_o;
  logic [1:0]        burst_len_o;
  logic              burst_last_o;

  int checks = 0;
  int fails  = 0;
  int stall_ctr = 0;

  always #5 clk_i = ~clk_i;

  line_burst_splitter dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_valid_i (line_valid_i),
    .line_ready_o (line_ready_o),
    .line_addr_i  (line_addr_i),
    .line_len_i   (line_len_i),
    .burst_valid_o(burst_valid_o),
    .burst_ready_i(burst_ready_i),
    .burst_addr_o (burst_addr_o),
    .burst_len_o  (burst_len_o),
    .burst_last_o (burst_last_o)
  );

  task automatic chk(string req, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // longest of 1/2/4/8 beats aligned at cur and ending at or before endb
  function automatic int exp_code(longint unsigned cur, longint unsigned endb);
    for (int k = 3; k > 0; k--) begin
      if ((cur % (64'd1 << k)) == 0 && cur + (64'd1 << k) <= endb) return k;
    end
    return 0;
  endfunction

  task automatic run_line(longint unsigned a, int len, bit stall);
    longint unsigned cur_b, end_b, held_addr;
    int k, held_len;
    bit held_last, exp_last;
    while (!line_ready_o) @(negedge clk_i);
    line_addr_i  = ADDR_W'(a);
    line_len_i   = LEN_W'(len);
    line_valid_i = 1'b1;
    @(negedge clk_i);
    line_valid_i = 1'b0;
    cur_b = a >> 4;
    end_b = (a + longint'(len) + 15) >> 4;
    if (len == 0) begin
      chk("R8", "no burst", burst_valid_o, 0);
      chk("R8", "ready", line_ready_o, 1);
      return;
    end
    chk("R10", "ready low while busy", line_ready_o, 0);
    while (cur_b < end_b) begin
      k = exp_code(cur_b, end_b);
      exp_last = (cur_b + (64'd1 << k) == end_b);
      if (!burst_valid_o) begin
        chk("R3", "valid missing", burst_valid_o, 1);
        return;
      end
      stall_ctr++;
      if (stall && (stall_ctr % 3 == 0)) begin
        burst_ready_i = 1'b0;
        held_addr = burst_addr_o;
        held_len  = burst_len_o;
        held_last = burst_last_o;
        @(negedge clk_i);
        chk("R9", "valid held", burst_valid_o, 1);
        chk("R9", "addr held", burst_addr_o, held_addr);
        chk("R9", "len held", burst_len_o, held_len);
        chk("R9", "last held", burst_last_o, held_last);
      end else begin
        chk("R2", "addr", burst_addr_o, cur_b << 4);
        chk("R6", "len code (R4: 0/1/2/3 = 1/2/4/8 beats)", burst_len_o, k);
        chk("R5", "alignment", burst_addr_o % (64'd16 << burst_len_o), 0);
        chk("R7", "last", burst_last_o, exp_last);
        burst_ready_i = 1'b1;
        @(negedge clk_i);
        burst_ready_i = 1'b0;
        cur_b += (64'd1 << k);
      end
    end
    chk("R3", "no extra burst", burst_valid_o, 0);
    chk("R10", "ready after last", line_ready_o, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int ofs [4] = '{0, 1, 8, 15};
    rst_ni        = 1'b0;
    line_valid_i  = 1'b0;
    line_addr_i   = '0;
    line_len_i    = '0;
    burst_ready_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1", "reset ready", line_ready_o, 1);
    chk("R1", "reset valid", burst_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "idle ready", line_ready_o, 1);
    for (int b = 0; b < 8; b++) begin
      for (int o = 0; o < 4; o++) begin
        for (int len = 0; len <= 140; len++) begin
          run_line(64'h8765_4321_0000 + longint'(b * 16 + ofs[o]), len, len[0]);
        end
      end
    end
    run_line(64'hFFFF_FFFF_F003, 300, 1'b1);
    run_line(64'h0000_0000_000F, 65535, 1'b0);
    run_line(64'h1234_5678_9ABF, 0, 1'b0);
    run_line(64'h1234_5678_9A70, 1, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule